// File: doc/BRIEF.md
# Address Collision Busy Arbiter

This block watches the two access ports of a shared memory. When both ports are enabled on the same address in the same cycle, it lets one of them continue and signals the other with an active-low busy indication. The port chosen to wait is the one whose enable-and-address combination became valid later. The busy indication also suppresses that port's write strobe, so the memory sees at most one write to the contested word. Port A is the left-hand port and port B the right-hand port. When both become valid in the same cycle, port B is made to wait.

A strap input selects master or slave operation. A master decides the outcome and drives both busy outputs. A slave does no arbitration. It takes a busy level per port from an external master and uses it only to gate that port's writes. Several slaves can therefore follow one master and form a wider word without split decisions. Each port produces a gated write enable, which is what the memory array should use. The array is outside this block. Everything runs on one clock.

Top module: `collision_arb`

## Requirements
- R1: In master mode, when either port's enable is low or the two addresses differ, both `a_busy_n` and `b_busy_n` are 1.
- R2: In master mode, when both enables are high on equal addresses, the port whose enable-and-address became valid in a later cycle gets its busy output at 0, and the other port's busy output stays 1.
- R3: When both ports become valid on the same address in the same cycle, port B gets busy 0 and port A busy 1. A port counts as valid in a cycle only if it was enabled at the same address at the previous clock edge. After reset neither port counts as previously valid.
- R4: `a_busy_n` and `b_busy_n` are never 0 at the same time.
- R5: A port's gated write enable is 1 exactly when that port's enable and write request are both 1 and its write is not inhibited. In master mode a write is inhibited while that port's busy output is 0.
- R6: The arbitration result does not depend on the write request inputs; a read collision yields the same busy pattern as a write collision.
- R7: A port that has won a collision keeps the grant for as long as its enable stays high and its address stays unchanged. This holds even when both ports are then equally old.
- R8: When the winner drops its enable or changes its address, its grant is released. A port that arrives later on the old address loses to the port still waiting there.
- R9: In slave mode (`master` = 0), both busy outputs are 1. A 0 on a port's `*_busy_in` forces that port's gated write enable to 0, and a 1 allows normal writes.
- R10: In master mode, the `*_busy_in` inputs have no effect on the gated write enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| master | input | 1 | 1 = master (arbitrates, drives busy), 0 = slave (busy pins gate writes) |
| a_ce | input | 1 | Port A enable, active high |
| a_addr | input | ADDR_W (15) | Port A address |
| a_wr | input | 1 | Port A write request |
| a_busy_in | input | 1 | Port A busy from an external master, active low, used in slave mode |
| a_busy_n | output | 1 | Port A busy indication, active low |
| a_wr_gated | output | 1 | Port A write enable toward the array |
| b_ce | input | 1 | Port B enable, active high |
| b_addr | input | ADDR_W (15) | Port B address |
| b_wr | input | 1 | Port B write request |
| b_busy_in | input | 1 | Port B busy from an external master, active low, used in slave mode |
| b_busy_n | output | 1 | Port B busy indication, active low |
| b_wr_gated | output | 1 | Port B write enable toward the array |

## Verification
The assertions assume that the `master` strap is held steady during operation. The grant-retention property assumes that the port inputs change only between clock edges, so that "previously valid" means the values seen at the last edge. The directed bench changes every input at the falling edge. It changes `master` only between scenarios, while both ports are idle. The bench first lets each scenario's arrival order settle over whole cycles and only then samples the combinational outputs.

// File: rtl/collision_arb_pkg.sv
package collision_arb_pkg;
  typedef enum logic [1:0] {
    SIDE_NONE = 2'd0,
    SIDE_A    = 2'd1,
    SIDE_B    = 2'd2
  } side_e;
endpackage

// File: rtl/collision_arb_rst_sync.sv
module collision_arb_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] chain_q;
  logic [LAST:0] chain_d;

  always_comb begin
    chain_d = {chain_q[LAST-1:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[LAST];
endmodule

// File: rtl/collision_arb_tracker.sv
module collision_arb_tracker #(
  parameter int ADDR_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce,
  input  logic [ADDR_W-1:0] addr,
  output logic              held
);
  logic              ce_q;
  logic [ADDR_W-1:0] addr_q;
  logic              addr_load;

  // address capture only while enabled
  assign addr_load = ce;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ce_q <= 1'b0;
    else        ce_q <= ce;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         addr_q <= '0;
    else if (addr_load) addr_q <= addr;
  end

  // valid now and already valid at the same address last edge
  assign held = ce && ce_q && (addr == addr_q);
endmodule

// File: rtl/collision_arb_decide.sv
module collision_arb_decide
  import collision_arb_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  enable,
  input  logic  collide,
  input  logic  a_held,
  input  logic  b_held,
  output side_e loser
);
  side_e owner_q;
  side_e owner_d;
  side_e loser_c;

  always_comb begin
    loser_c = SIDE_NONE;
    owner_d = owner_q;
    if (!enable) begin
      owner_d = SIDE_NONE;
    end else if (collide) begin
      if (owner_q == SIDE_A && a_held)      loser_c = SIDE_B;
      else if (owner_q == SIDE_B && b_held) loser_c = SIDE_A;
      else if (a_held && !b_held)           loser_c = SIDE_B;
      else if (b_held && !a_held)           loser_c = SIDE_A;
      else                                  loser_c = SIDE_B;
      owner_d = (loser_c == SIDE_B) ? SIDE_A : SIDE_B;
    end else begin
      if (owner_q == SIDE_A && !a_held) owner_d = SIDE_NONE;
      if (owner_q == SIDE_B && !b_held) owner_d = SIDE_NONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) owner_q <= SIDE_NONE;
    else        owner_q <= owner_d;
  end

  assign loser = loser_c;
endmodule

// File: rtl/collision_arb.sv
module collision_arb
  import collision_arb_pkg::*;
#(
  parameter int ADDR_W      = 15,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              master,
  input  logic              a_ce,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic              a_wr,
  input  logic              a_busy_in,
  output logic              a_busy_n,
  output logic              a_wr_gated,
  input  logic              b_ce,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic              b_wr,
  input  logic              b_busy_in,
  output logic              b_busy_n,
  output logic              b_wr_gated
);
  localparam int NPORT = 2;

  logic rst_sync_n;
  logic collide;
  side_e loser;

  logic [NPORT-1:0]       ce_v;
  logic [ADDR_W-1:0]      addr_v [NPORT];
  logic [NPORT-1:0]       wr_v;
  logic [NPORT-1:0]       bin_v;
  logic [NPORT-1:0]       held_v;
  logic [NPORT-1:0]       lose_v;
  logic [NPORT-1:0]       inhibit_v;
  logic [NPORT-1:0]       gated_v;

  collision_arb_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  assign ce_v   = {b_ce, a_ce};
  assign wr_v   = {b_wr, a_wr};
  assign bin_v  = {b_busy_in, a_busy_in};
  assign addr_v[0] = a_addr;
  assign addr_v[1] = b_addr;

  genvar p;
  generate
    for (p = 0; p < NPORT; p++) begin : g_port
      collision_arb_tracker #(.ADDR_W(ADDR_W)) u_trk (
        .clk(clk), .rst_n(rst_sync_n),
        .ce(ce_v[p]), .addr(addr_v[p]), .held(held_v[p])
      );
      // master: own decision; slave: external busy level
      assign inhibit_v[p] = master ? lose_v[p] : !bin_v[p];
      assign gated_v[p]   = ce_v[p] && wr_v[p] && !inhibit_v[p];
    end
  endgenerate

  assign collide = a_ce && b_ce && (a_addr == b_addr);

  collision_arb_decide u_dec (
    .clk(clk), .rst_n(rst_sync_n), .enable(master),
    .collide(collide), .a_held(held_v[0]), .b_held(held_v[1]),
    .loser(loser)
  );

  assign lose_v[0] = master && (loser == SIDE_A);
  assign lose_v[1] = master && (loser == SIDE_B);

  assign a_busy_n   = !lose_v[0];
  assign b_busy_n   = !lose_v[1];
  assign a_wr_gated = gated_v[0];
  assign b_wr_gated = gated_v[1];
endmodule

// File: rtl/collision_arb_chk.sv
module collision_arb_chk #(
  parameter int ADDR_W = 15
) (
  input logic              clk,
  input logic              rst_n,
  input logic              master,
  input logic              a_ce,
  input logic [ADDR_W-1:0] a_addr,
  input logic              a_busy_in,
  input logic              a_busy_n,
  input logic              a_wr_gated,
  input logic              b_ce,
  input logic [ADDR_W-1:0] b_addr,
  input logic              b_busy_in,
  input logic              b_busy_n,
  input logic              b_wr_gated
);
  logic collide;
  logic past_ok;

  assign collide = a_ce && b_ce && (a_addr == b_addr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  // R1
  idle_both_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (master && !collide) |-> (a_busy_n && b_busy_n));

  // R2
  single_loser_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (master && collide) |-> ($countones({!a_busy_n, !b_busy_n}) == 1));

  // R4
  never_both_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!a_busy_n && !b_busy_n));

  // R5
  a_busy_blocks_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !a_busy_n |-> !a_wr_gated);

  // R5
  b_busy_blocks_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !b_busy_n |-> !b_wr_gated);

  // R7
  b_keeps_losing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && master && $past(master) && collide && $past(collide) &&
     $stable(a_addr) && $stable(b_addr) && !$past(b_busy_n)) |-> !b_busy_n);

  // R7
  a_keeps_losing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && master && $past(master) && collide && $past(collide) &&
     $stable(a_addr) && $stable(b_addr) && !$past(a_busy_n)) |-> !a_busy_n);

  // R9
  slave_busy_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !master |-> (a_busy_n && b_busy_n));

  // R9
  slave_a_inhibit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!master && !a_busy_in) |-> !a_wr_gated);

  // R9
  slave_b_inhibit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!master && !b_busy_in) |-> !b_wr_gated);
endmodule

bind collision_arb collision_arb_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .master(master),
  .a_ce(a_ce), .a_addr(a_addr), .a_busy_in(a_busy_in),
  .a_busy_n(a_busy_n), .a_wr_gated(a_wr_gated),
  .b_ce(b_ce), .b_addr(b_addr), .b_busy_in(b_busy_in),
  .b_busy_n(b_busy_n), .b_wr_gated(b_wr_gated)
);

// File: tb/test_collision_arb.sv
module test_collision_arb;
  localparam int AW = 15;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          master;
  logic          a_ce, a_wr, a_busy_in, b_ce, b_wr, b_busy_in;
  logic [AW-1:0] a_addr, b_addr;
  logic          a_busy_n, a_wr_gated, b_busy_n, b_wr_gated;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  collision_arb i_collision_arb (
    .clk(clk), .rst_n(rst_n), .master(master),
    .a_ce(a_ce), .a_addr(a_addr), .a_wr(a_wr), .a_busy_in(a_busy_in),
    .a_busy_n(a_busy_n), .a_wr_gated(a_wr_gated),
    .b_ce(b_ce), .b_addr(b_addr), .b_wr(b_wr), .b_busy_in(b_busy_in),
    .b_busy_n(b_busy_n), .b_wr_gated(b_wr_gated)
  );

  task automatic check(input string req, input string what,
                       input logic [3:0] act, input logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  // outputs packed as {a_busy_n, b_busy_n, a_wr_gated, b_wr_gated}
  function automatic logic [3:0] outs();
    return {a_busy_n, b_busy_n, a_wr_gated, b_wr_gated};
  endfunction

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic drive(input logic ace, input logic [AW-1:0] aad, input logic awr,
                       input logic bce, input logic [AW-1:0] bad, input logic bwr);
    a_ce = ace; a_addr = aad; a_wr = awr;
    b_ce = bce; b_addr = bad; b_wr = bwr;
    #1;
  endtask

  task automatic idle();
    cyc(); drive(0, '0, 0, 0, '0, 0); cyc();
  endtask

  task automatic t_reset();
    master = 1; a_busy_in = 1; b_busy_in = 1;
    a_ce = 0; b_ce = 0; a_wr = 0; b_wr = 0; a_addr = '0; b_addr = '0;
    rst_n = 0;
    repeat (3) cyc();
    #1 check("R1", "reset idle outputs", outs(), 4'b1100);
    rst_n = 1;
    repeat (4) cyc();
  endtask

  task automatic t_no_match();
    cyc(); drive(1, 15'h0100, 1, 1, 15'h0200, 1);
    check("R1", "different addresses", outs(), 4'b1111);
    cyc(); drive(1, 15'h7FFE, 1, 0, 15'h7FFE, 1);
    check("R1", "B disabled same address", outs(), 4'b1110);
    idle();
  endtask

  task automatic t_b_late();
    cyc(); drive(1, 15'h1234, 1, 0, '0, 0);
    cyc(); drive(1, 15'h1234, 1, 1, 15'h1234, 1);
    check("R2", "B arrives later loses", outs(), 4'b1010);
    idle();
  endtask

  task automatic t_a_late();
    cyc(); drive(0, '0, 0, 1, 15'h0042, 1);
    cyc(); drive(1, 15'h0042, 1, 1, 15'h0042, 1);
    check("R2", "A arrives later loses", outs(), 4'b0101);
    idle();
  endtask

  task automatic t_tie();
    cyc(); drive(1, 15'h7FFF, 1, 1, 15'h7FFF, 1);
    check("R3", "same-cycle arrival B loses", outs(), 4'b1010);
    idle();
  endtask

  task automatic t_read_collision();
    cyc(); drive(1, 15'h7FFF, 0, 1, 15'h7FFF, 0);
    check("R6", "read tie same busy pattern", outs(), 4'b1000);
    idle();
    cyc(); drive(0, '0, 0, 1, 15'h0033, 0);
    cyc(); drive(1, 15'h0033, 1, 1, 15'h0033, 0);
    check("R6", "A late write vs B read", outs(), 4'b0100);
    idle();
  endtask

  task automatic t_grant_kept();
    cyc(); drive(0, '0, 0, 1, 15'h0555, 1);
    cyc(); drive(1, 15'h0555, 1, 1, 15'h0555, 1);
    check("R2", "A late loses first cycle", outs(), 4'b0101);
    cyc(); #1;
    check("R7", "both old, B keeps grant", outs(), 4'b0101);
    cyc(); #1;
    check("R7", "third cycle B keeps grant", outs(), 4'b0101);
    // winner B moves away: grant released
    cyc(); drive(1, 15'h0555, 1, 1, 15'h0666, 1);
    check("R8", "winner moved, no collision", outs(), 4'b1111);
    cyc(); drive(1, 15'h0555, 1, 1, 15'h0555, 1);
    check("R8", "B returns late and loses", outs(), 4'b1010);
    cyc(); #1;
    check("R7", "A keeps new grant", outs(), 4'b1010);
    // winner A drops enable for one cycle
    cyc(); drive(0, 15'h0555, 1, 1, 15'h0555, 1);
    check("R8", "winner disabled", outs(), 4'b1101);
    cyc(); drive(1, 15'h0555, 1, 1, 15'h0555, 1);
    check("R8", "A re-enables late and loses", outs(), 4'b0101);
    idle();
  endtask

  task automatic t_master_ignores_busy_in();
    a_busy_in = 0; b_busy_in = 0;
    cyc(); drive(1, 15'h0001, 1, 1, 15'h0002, 1);
    check("R10", "master ignores busy_in", outs(), 4'b1111);
    idle();
    a_busy_in = 1; b_busy_in = 1;
  endtask

  task automatic t_slave();
    master = 0;
    idle();
    cyc(); drive(1, 15'h0777, 1, 1, 15'h0777, 1);
    check("R9", "slave collision, inputs high", outs(), 4'b1111);
    a_busy_in = 0; #1;
    check("R9", "slave A busy_in low blocks A", outs(), 4'b1101);
    b_busy_in = 0; a_busy_in = 1; #1;
    check("R9", "slave B busy_in low blocks B", outs(), 4'b1110);
    cyc(); drive(1, 15'h0010, 0, 1, 15'h0020, 1);
    check("R9", "slave read not gated output", outs(), 4'b1100);
    b_busy_in = 1; #1;
    check("R5", "slave write released", outs(), 4'b1101);
    idle();
    master = 1;
    idle();
  endtask

  initial begin
    t_reset();
    t_no_match();
    t_b_late();
    t_a_late();
    t_tie();
    t_read_collision();
    t_grant_kept();
    t_master_ignores_busy_in();
    t_slave();
    // R4 spot check after all scenarios
    cyc(); drive(1, 15'h0ABC, 1, 1, 15'h0ABC, 1);
    check("R4", "not both busy", {2'b00, (a_busy_n | b_busy_n), 1'b1}, 4'b0011);
    idle();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule